// File: doc/BRIEF.md
# Paced Single-Channel DMA Transfer Engine

This block is one DMA channel that copies 32-bit words from a source address to a destination address, or writes a constant fill word to the destination. Software programs seven registers through a simple word-wide register port and then sets the enable bit. The channel asks an external arbiter for the bus and moves data in blocks of 2^x words. While a block is in flight it keeps the bus. Between blocks it pauses for a programmable interval, and that interval is counted by a timer whose tick is the clock divided by 1, 4, 16 or 64.

A transfer can start in one of three ways. In immediate mode it runs as soon as it is enabled and moves one event's worth of words. In counted mode it waits for a selected trigger line, moves the per-event count on each trigger, and stops once a total word count has been moved. In repeat mode it serves every trigger and never stops on its own. Each address steps by +4 or -4, or is held. Either address can be restored from its programmed value at the start of each trigger-driven event.

The channel controller is a state machine with these states:
- ST_IDLE: disabled.
- ST_ARM: waiting for a trigger.
- ST_REQ: requesting the bus.
- ST_READ: reading a source word.
- ST_WRITE: writing a destination word.
- ST_GAP: waiting out the interval between blocks.
- ST_DONE: a one-cycle finish.

Its transitions are:
- ST_IDLE→ST_REQ on an immediate enable, ST_IDLE→ST_ARM on a triggered enable.
- ST_ARM→ST_REQ on the selected trigger.
- ST_REQ→ST_READ on grant, or ST_REQ→ST_WRITE on grant in fill mode.
- ST_READ→ST_WRITE.
- ST_WRITE→ST_READ or ST_WRITE for the next word of the block.
- ST_WRITE→ST_GAP at the end of a block.
- ST_WRITE→ST_ARM at the end of an event.
- ST_WRITE→ST_DONE at the finish.
- ST_GAP→ST_REQ when the interval expires.
- ST_DONE→ST_IDLE.
- Any state→ST_IDLE when software clears the enable bit.

Top module: `paced_dma_chan`

## Requirements
- R1: After reset the channel is idle. The control register reads 0, and bus_req and irq are low.
- R2: Register offsets on reg_addr are as follows. Reading an offset returns the programmed value, truncated to its width. Writing the source or destination offset also loads that side's working address.

  | Offset | Register |
  |---|---|
  | 0 | control |
  | 1 | source address |
  | 2 | destination address |
  | 3 | total word count (28 bits) |
  | 4 | per-event word count (24 bits) |
  | 5 | pacing: interval in bits 15:0, prescaler in bits 17:16 |
  | 6 | fill word |
- R3: Control bits 11:10 set the destination update: 0 adds 4, 1 subtracts 4, 2 and 3 hold. Control bits 14:13 set the source update: 0 adds 4, 1 subtracts 4, 2 holds. Each address steps once per word moved.
- R4: When control bits 14:13 are 3, no source reads are issued and every destination write carries the fill word.
- R5: Control bits 19:16 give x, and words move in blocks of 2^x. Within a block, the next word's read follows the previous write on the next cycle. An event shorter than a block ends the block early.
- R6: After a block that does not end its event, the next read comes exactly I·4^P + 3 cycles after the block's last write, where I is the interval and P is the prescaler, assuming a grant in the cycle of the request.
- R7: Immediate mode (control bit 28) starts on enable, moves the per-event count once, and then finishes. It ignores both the total count and repeat mode.
- R8: Without immediate mode, control bits 27:24 select which trig_evt bit starts an event. Pulses on any other bit are ignored.
- R9: With neither immediate (bit 28) nor repeat (bit 29) set, each trigger moves the per-event count. The channel finishes as soon as the total count has been moved.
- R10: Repeat mode (control bit 29) serves every trigger, ignores the total count and stays enabled.
- R11: Control bit 15 (source) and bit 12 (destination) restore the working address from the programmed value at the start of each trigger-driven event.
- R12: Control bit 31 is the enable/busy bit, and writing it as 1 starts an idle channel. On finish, busy clears and, if bit 30 is set, irq pulses for exactly one cycle. Writing bit 31 as 0 stops the channel at once with no irq. While busy, control writes change only the enable bit.
- R13: mem_rd and mem_wr are never high together, and either one is high only while bus_req is high. Read data on mem_rdata is taken in the cycle after mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| trig_evt | input | 16 | Trigger event lines, one cycle pulses |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 32 | Word address (byte address, multiple of 4) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions take for granted that software programs source and destination addresses that are multiples of 4. They also assume the arbiter keeps bus_gnt high for as long as bus_req stays high once it has granted, and that per-event counts are nonzero. The stimulus meets all of this. It uses word-aligned addresses only. Its arbiter model ties the grant to the request. Its per-event counts lie between 2 and 8. Triggers are pulsed only while the channel is waiting in ST_ARM, and aborts are issued only from that state.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int RADDR_W = 3;
    localparam int PRE_W   = 2;
    localparam int BSZ_W   = 4;
    localparam int TRG_W   = 4;
    localparam int TRIG_N  = 1 << TRG_W;

    localparam logic [RADDR_W-1:0] RO_CTRL = 3'd0;
    localparam logic [RADDR_W-1:0] RO_SRC  = 3'd1;
    localparam logic [RADDR_W-1:0] RO_DST  = 3'd2;
    localparam logic [RADDR_W-1:0] RO_TOT  = 3'd3;
    localparam logic [RADDR_W-1:0] RO_EVT  = 3'd4;
    localparam logic [RADDR_W-1:0] RO_PACE = 3'd5;
    localparam logic [RADDR_W-1:0] RO_FILL = 3'd6;

    localparam int CB_DMODE = 10;
    localparam int CB_DRLD  = 12;
    localparam int CB_SMODE = 13;
    localparam int CB_SRLD  = 15;
    localparam int CB_BSZ   = 16;
    localparam int CB_TRG   = 24;
    localparam int CB_IMM   = 28;
    localparam int CB_RPT   = 29;
    localparam int CB_IRQ   = 30;
    localparam int CB_EN    = 31;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_REQ, ST_READ, ST_WRITE, ST_GAP, ST_DONE
    } chan_state_t;

    typedef enum logic [1:0] {
        AM_INC  = 2'd0,
        AM_DEC  = 2'd1,
        AM_HOLD = 2'd2,
        AM_NONE = 2'd3
    } addr_mode_t;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TOT_W  = 28,
    parameter int EV_W   = 24,
    parameter int IVL_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               busy,
    output logic [31:0]        reg_rdata,
    output logic [ADDR_W-1:0]  src_prog,
    output logic [ADDR_W-1:0]  dst_prog,
    output logic               src_wr,
    output logic               dst_wr,
    output logic [TOT_W-1:0]   tot_cfg,
    output logic [EV_W-1:0]    ev_cfg,
    output logic [IVL_W-1:0]   ivl_cfg,
    output logic [PRE_W-1:0]   pre_cfg,
    output logic [31:0]        fill_cfg,
    output logic [30:0]        ctrl_cfg
);
    logic hit_ctrl, hit_pace;

    assign src_wr   = reg_we && (reg_addr == RO_SRC);
    assign dst_wr   = reg_we && (reg_addr == RO_DST);
    assign hit_ctrl = reg_we && (reg_addr == RO_CTRL);
    assign hit_pace = reg_we && (reg_addr == RO_PACE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prog <= '0;
            dst_prog <= '0;
            tot_cfg  <= '0;
            ev_cfg   <= '0;
            ivl_cfg  <= '0;
            pre_cfg  <= '0;
            fill_cfg <= '0;
            ctrl_cfg <= '0;
        end else begin
            if (src_wr) src_prog <= reg_wdata[ADDR_W-1:0];
            if (dst_wr) dst_prog <= reg_wdata[ADDR_W-1:0];
            if (reg_we && reg_addr == RO_TOT) tot_cfg <= reg_wdata[TOT_W-1:0];
            if (reg_we && reg_addr == RO_EVT) ev_cfg  <= reg_wdata[EV_W-1:0];
            if (hit_pace) begin
                ivl_cfg <= reg_wdata[IVL_W-1:0];
                pre_cfg <= reg_wdata[16 +: PRE_W];
            end
            if (reg_we && reg_addr == RO_FILL) fill_cfg <= reg_wdata;
            // mode fields freeze while a transfer is running
            if (hit_ctrl && !busy) ctrl_cfg <= reg_wdata[30:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            RO_CTRL: reg_rdata = {busy, ctrl_cfg};
            RO_SRC:  reg_rdata = 32'(src_prog);
            RO_DST:  reg_rdata = 32'(dst_prog);
            RO_TOT:  reg_rdata = 32'(tot_cfg);
            RO_EVT:  reg_rdata = 32'(ev_cfg);
            RO_PACE: reg_rdata = 32'({pre_cfg, ivl_cfg});
            RO_FILL: reg_rdata = fill_cfg;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              reload,
    input  logic [ADDR_W-1:0] reload_val,
    input  logic              step,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (reload) begin
            addr <= reload_val;
        end else if (step) begin
            unique case (addr_mode_t'(mode))
                AM_INC:  addr <= addr + WORD_BYTES;
                AM_DEC:  addr <= addr - WORD_BYTES;
                default: addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/pdma_pacer.sv
module pdma_pacer
    import pdma_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IVL_W-1:0] ivl,
    input  logic [PRE_W-1:0] pre,
    output logic             expired
);
    localparam int PS_W = 2 * ((1 << PRE_W) - 1);

    logic [IVL_W-1:0] ivl_q;
    logic [PS_W-1:0]  ps_q;
    logic [PS_W-1:0]  ps_top;

    // divider of 4^pre, so the last prescale count is 4^pre - 1
    assign ps_top  = (PS_W'(1) << {pre, 1'b0}) - PS_W'(1);
    assign expired = (ivl_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q <= '0;
            ps_q  <= '0;
        end else if (start) begin
            ivl_q <= ivl;
            ps_q  <= '0;
        end else if (ivl_q != '0) begin
            if (ps_q == ps_top) begin
                ps_q  <= '0;
                ivl_q <= ivl_q - IVL_W'(1);
            end else begin
                ps_q <= ps_q + PS_W'(1);
            end
        end
    end
endmodule

// File: rtl/paced_dma_chan.sv
module paced_dma_chan
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TOT_W  = 28,
    parameter int EV_W   = 24,
    parameter int IVL_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [15:0]        trig_evt,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               irq
);
    localparam int BLK_W = 1 << BSZ_W;

    chan_state_t state_q, state_d;

    logic [ADDR_W-1:0] src_prog, dst_prog, src_addr, dst_addr;
    logic              src_wr, dst_wr;
    logic [TOT_W-1:0]  tot_cfg, tot_left_q;
    logic [EV_W-1:0]   ev_cfg, ev_left_q;
    logic [IVL_W-1:0]  ivl_cfg;
    logic [PRE_W-1:0]  pre_cfg;
    logic [31:0]       fill_cfg;
    logic [30:0]       ctrl_cfg;
    logic [BLK_W-1:0]  blk_left_q;
    logic              busy;
    logic              gap_expired;

    logic [1:0]       dmode, smode;
    logic             drld, srld, imm, rpt, irq_en, counted, fill_mode;
    logic [BSZ_W-1:0] bsz;
    logic [TRG_W-1:0] trg;
    logic             unused_ctrl_bits;

    assign dmode     = ctrl_cfg[CB_DMODE +: 2];
    assign drld      = ctrl_cfg[CB_DRLD];
    assign smode     = ctrl_cfg[CB_SMODE +: 2];
    assign srld      = ctrl_cfg[CB_SRLD];
    assign bsz       = ctrl_cfg[CB_BSZ +: BSZ_W];
    assign trg       = ctrl_cfg[CB_TRG +: TRG_W];
    assign imm       = ctrl_cfg[CB_IMM];
    assign rpt       = ctrl_cfg[CB_RPT];
    assign irq_en    = ctrl_cfg[CB_IRQ];
    assign counted   = !imm && !rpt;
    assign fill_mode = (addr_mode_t'(smode) == AM_NONE);
    assign unused_ctrl_bits = ^{ctrl_cfg[9:0], ctrl_cfg[23:20]};

    assign busy = (state_q != ST_IDLE);

    // control-port events seen by the state machine
    logic ctrl_hit, start_wr, abort_wr, trig_hit;
    assign ctrl_hit = reg_we && (reg_addr == RO_CTRL);
    assign start_wr = ctrl_hit && reg_wdata[CB_EN] && (state_q == ST_IDLE);
    assign abort_wr = ctrl_hit && !reg_wdata[CB_EN] && busy;
    assign trig_hit = trig_evt[trg];

    // end-of-word conditions evaluated in ST_WRITE
    logic ev_last, tot_last, blk_last, evt_end;
    assign ev_last  = (ev_left_q == EV_W'(1));
    assign tot_last = counted && (tot_left_q == TOT_W'(1));
    assign blk_last = (blk_left_q == BLK_W'(1));
    assign evt_end  = ev_last || tot_last;

    logic evt_begin;
    assign evt_begin = (state_q == ST_ARM) && trig_hit && !abort_wr;

    pdma_regs #(
        .ADDR_W(ADDR_W), .TOT_W(TOT_W), .EV_W(EV_W), .IVL_W(IVL_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .reg_rdata(reg_rdata),
        .src_prog(src_prog), .dst_prog(dst_prog), .src_wr(src_wr), .dst_wr(dst_wr),
        .tot_cfg(tot_cfg), .ev_cfg(ev_cfg), .ivl_cfg(ivl_cfg), .pre_cfg(pre_cfg),
        .fill_cfg(fill_cfg), .ctrl_cfg(ctrl_cfg)
    );

    pdma_addr_gen #(.ADDR_W(ADDR_W)) src_gen_i (
        .clk(clk), .rst_n(rst_n),
        .load(src_wr), .load_val(src_prog_next(reg_wdata)),
        .reload(evt_begin && srld), .reload_val(src_prog),
        .step(state_q == ST_READ), .mode(smode), .addr(src_addr)
    );

    pdma_addr_gen #(.ADDR_W(ADDR_W)) dst_gen_i (
        .clk(clk), .rst_n(rst_n),
        .load(dst_wr), .load_val(src_prog_next(reg_wdata)),
        .reload(evt_begin && drld), .reload_val(dst_prog),
        .step(state_q == ST_WRITE), .mode(dmode), .addr(dst_addr)
    );

    pdma_pacer #(.IVL_W(IVL_W)) pacer_i (
        .clk(clk), .rst_n(rst_n),
        .start((state_q == ST_WRITE) && !evt_end && blk_last),
        .ivl(ivl_cfg), .pre(pre_cfg), .expired(gap_expired)
    );

    function automatic logic [ADDR_W-1:0] src_prog_next(input logic [31:0] w);
        return w[ADDR_W-1:0];
    endfunction

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (abort_wr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_wr) state_d = reg_wdata[CB_IMM] ? ST_REQ : ST_ARM;
                ST_ARM:   if (trig_hit) state_d = ST_REQ;
                ST_REQ:   if (bus_gnt) state_d = fill_mode ? ST_WRITE : ST_READ;
                ST_READ:  state_d = ST_WRITE;
                ST_WRITE: begin
                    if (evt_end) begin
                        if (imm || tot_last) state_d = ST_DONE;
                        else                 state_d = ST_ARM;
                    end else if (blk_last) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d = fill_mode ? ST_WRITE : ST_READ;
                    end
                end
                ST_GAP:   if (gap_expired) state_d = ST_REQ;
                ST_DONE:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and word counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ev_left_q  <= '0;
            tot_left_q <= '0;
            blk_left_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_wr) begin
                tot_left_q <= tot_cfg;
                ev_left_q  <= ev_cfg;
            end
            if (evt_begin) ev_left_q <= ev_cfg;
            if (state_q == ST_REQ) blk_left_q <= BLK_W'(1) << bsz;
            if (state_q == ST_WRITE) begin
                ev_left_q  <= ev_left_q - EV_W'(1);
                blk_left_q <= blk_left_q - BLK_W'(1);
                if (counted) tot_left_q <= tot_left_q - TOT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = dst_addr;
        mem_wdata = fill_mode ? fill_cfg : mem_rdata;
        irq       = 1'b0;
        unique case (state_q)
            ST_REQ:   bus_req = 1'b1;
            ST_READ:  begin bus_req = 1'b1; mem_rd = 1'b1; mem_addr = src_addr; end
            ST_WRITE: begin bus_req = 1'b1; mem_wr = 1'b1; end
            ST_DONE:  irq = irq_en;
            default:  ;
        endcase
    end
endmodule

// File: rtl/pdma_chk.sv
module pdma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              busy
);
    // R13
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R13
    bus_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_req && bus_gnt));
    // R13
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr || !busy));
    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));
    // R12
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R12
    irq_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !busy);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !irq));
endmodule

bind paced_dma_chan pdma_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .irq(irq), .busy(busy)
);

// File: tb/paced_dma_chan_tb_top.sv
module paced_dma_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] trig_evt = '0;
    logic        bus_req, bus_gnt, mem_rd, mem_wr, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;
    assign bus_gnt = bus_req;

    paced_dma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_evt(trig_evt),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'hC0DE_0000 ^ a;
    endfunction

    // source memory model: registered read of a fixed pattern
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    int    n_checks = 0, n_err = 0;
    string cur_req = "R3";
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    int cyc = 0, last_wr = -1, max_gap = 0, long_gaps = 0;
    int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] a, input int m);
        if (m == 0) return a + 32'd4;
        if (m == 1) return a - 32'd4;
        return a;
    endfunction

    // driver side of the scoreboard
    task automatic push_seq(input logic [31:0] sa, input int sm, input logic [31:0] da,
                            input int dm, input int n, input logic [31:0] fillv);
        for (int k = 0; k < n; k++) begin
            exp_addr_q.push_back(da);
            exp_data_q.push_back(sm == 3 ? fillv : pat(sa));
            sa = nxt(sa, sm);
            da = nxt(da, dm);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (irq) irq_cnt++;
            if (mem_rd) begin
                rd_cnt++;
                if (last_wr >= 0) begin
                    if (cyc - last_wr > max_gap) max_gap = cyc - last_wr;
                    if (cyc - last_wr > 1) long_gaps++;
                end
            end
            if (mem_wr) begin
                wr_cnt++;
                last_wr = cyc;
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, cur_req, mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea, ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    check(mem_addr == ea, cur_req, mem_addr, ea);
                    check(mem_wdata == ed, cur_req, mem_wdata, ed);
                end
            end
        end
    end

    task automatic clear_mon(input string req);
        cur_req = req;
        last_wr = -1; max_gap = 0; long_gaps = 0;
        rd_cnt = 0; wr_cnt = 0; irq_cnt = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    task automatic fire(input int b);
        @(negedge clk);
        trig_evt = 16'(1) << b;
        @(negedge clk);
        trig_evt = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            #1;
            if (!reg_rdata[31]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_addr_q.size() == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit en, input bit ie, input bit rp, input bit im,
                                       input int tg, input int bz, input bit sr, input int sm,
                                       input bit dr, input int dm);
        return {en, ie, rp, im, 4'(tg), 4'b0, 4'(bz), sr, 2'(sm), dr, 2'(dm), 10'b0};
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'(cyc), 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v);
        check(v == 32'd0, "R1 ctrl", v, 32'd0);
        check(!bus_req && !irq, "R1 outputs", {30'b0, bus_req, irq}, 32'd0);

        // R2 register readback and widths
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v);
        check(v == 32'h00FF_FFFF, "R2 event count width", v, 32'h00FF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v);
        check(v == 32'h0FFF_FFFF, "R2 total width", v, 32'h0FFF_FFFF);

        // R7 immediate, inc/inc, blocks of 2, paced gap (R5, R6)
        clear_mon("R7");
        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'd1);
        wr(3'd4, 32'd5);
        wr(3'd5, 32'h0001_0002);
        push_seq(32'h1000, 0, 32'h2000, 0, 5, 32'h0);
        wr(3'd0, mk(1, 1, 0, 1, 0, 1, 0, 0, 0, 0));
        wait_idle();
        check(exp_addr_q.size() == 0, "R7 all words moved", 32'(exp_addr_q.size()), 32'd0);
        check(wr_cnt == 5, "R7 total ignored", 32'(wr_cnt), 32'd5);
        check(irq_cnt == 1, "R12 irq once", 32'(irq_cnt), 32'd1);
        check(max_gap == 11, "R6 interval 2 prescale 4", 32'(max_gap), 32'd11);
        check(long_gaps == 2, "R5 block boundaries", 32'(long_gaps), 32'd2);
        rd(3'd0, v);
        check(!v[31], "R12 busy cleared", {31'b0, v[31]}, 32'd0);
        rd(3'd1, v);
        check(v == 32'h1000, "R2 source readback", v, 32'h1000);
        rd(3'd5, v);
        check(v == 32'h0001_0002, "R2 pacing readback", v, 32'h0001_0002);

        // R3 source decrement, destination hold, irq disabled
        clear_mon("R3");
        wr(3'd1, 32'h0000_1040);
        wr(3'd2, 32'h0000_3000);
        wr(3'd4, 32'd3);
        push_seq(32'h1040, 1, 32'h3000, 2, 3, 32'h0);
        wr(3'd0, mk(1, 0, 0, 1, 0, 3, 0, 1, 0, 2));
        wait_idle();
        check(wr_cnt == 3, "R3 word count", 32'(wr_cnt), 32'd3);
        check(irq_cnt == 0, "R12 irq disabled", 32'(irq_cnt), 32'd0);

        // R4 fill, destination decrement, zero interval
        clear_mon("R4");
        wr(3'd2, 32'h0000_4010);
        wr(3'd4, 32'd4);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'hF111_0A5A);
        push_seq(32'h0, 3, 32'h4010, 1, 4, 32'hF111_0A5A);
        wr(3'd0, mk(1, 1, 0, 1, 0, 1, 0, 3, 0, 1));
        wait_idle();
        check(rd_cnt == 0, "R4 no source reads", 32'(rd_cnt), 32'd0);
        check(wr_cnt == 4, "R4 fill writes", 32'(wr_cnt), 32'd4);

        // R5 and R6: blocks of 4, interval 3, prescale 1
        clear_mon("R5");
        wr(3'd1, 32'h0000_1300);
        wr(3'd2, 32'h0000_7000);
        wr(3'd4, 32'd8);
        wr(3'd5, 32'h0000_0003);
        push_seq(32'h1300, 0, 32'h7000, 0, 8, 32'h0);
        wr(3'd0, mk(1, 0, 0, 1, 0, 2, 0, 0, 0, 0));
        wait_idle();
        check(long_gaps == 1, "R5 one boundary in 8 words", 32'(long_gaps), 32'd1);
        check(max_gap == 6, "R6 interval 3 prescale 1", 32'(max_gap), 32'd6);

        // R8, R9, R11: counted triggered mode with source reload
        clear_mon("R11");
        wr(3'd1, 32'h0000_1100);
        wr(3'd2, 32'h0000_5000);
        wr(3'd3, 32'd6);
        wr(3'd4, 32'd2);
        wr(3'd5, 32'h0);
        wr(3'd0, mk(1, 1, 0, 0, 5, 2, 1, 0, 0, 0));
        fire(3);
        repeat (20) @(negedge clk);
        check(wr_cnt == 0, "R8 other trigger ignored", 32'(wr_cnt), 32'd0);
        rd(3'd0, v);
        check(v[31], "R8 armed and busy", {31'b0, v[31]}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            push_seq(32'h1100, 0, 32'h5000 + 32'(8 * k), 0, 2, 32'h0);
            fire(5);
            wait_drain();
            if (k < 2) begin
                rd(3'd0, v);
                check(v[31], "R9 busy before total reached", {31'b0, v[31]}, 32'd1);
            end
        end
        wait_idle();
        check(wr_cnt == 6, "R9 total words", 32'(wr_cnt), 32'd6);
        check(irq_cnt == 1, "R9 finish irq", 32'(irq_cnt), 32'd1);
        rd(3'd0, v);
        check(!v[31], "R9 self disable", {31'b0, v[31]}, 32'd0);

        // R10 repeat with destination reload, then abort (R12)
        clear_mon("R10");
        wr(3'd1, 32'h0000_1200);
        wr(3'd2, 32'h0000_6000);
        wr(3'd3, 32'd1);
        wr(3'd5, 32'h0000_0001);
        wr(3'd0, mk(1, 1, 1, 0, 2, 0, 0, 0, 1, 0));
        for (int k = 0; k < 3; k++) begin
            push_seq(32'h1200 + 32'(8 * k), 0, 32'h6000, 0, 2, 32'h0);
            fire(2);
            wait_drain();
        end
        check(wr_cnt == 6, "R10 total ignored", 32'(wr_cnt), 32'd6);
        rd(3'd0, v);
        check(v[31], "R10 stays enabled", {31'b0, v[31]}, 32'd1);
        check(irq_cnt == 0, "R10 no finish irq", 32'(irq_cnt), 32'd0);
        wr(3'd0, 32'h0);
        repeat (3) @(negedge clk);
        rd(3'd0, v);
        check(!v[31], "R12 abort clears busy", {31'b0, v[31]}, 32'd0);
        check(irq_cnt == 0, "R12 abort without irq", 32'(irq_cnt), 32'd0);
        check(!bus_req, "R13 bus released", {31'b0, bus_req}, 32'd0);

        finish_run();
    end
endmodule